// File: doc/BRIEF.md
# Four-Bank Static Memory Bus Sequencer

This block turns single read and write requests from an internal valid/ready port into strobe sequences on an asynchronous external static-memory bus. Four chip-select banks share that bus. The two top address bits pick the bank. Each bank has its own programmed setup, access and hold counts, its own data width (8 or 16 bits) and its own page-read option.

An access runs through a fixed order of phases. The address goes out first. Chip-select falls after the bank's address setup count. Output-enable or write-enable falls after the chip-select setup count and stays low for the access count. Chip-select rises after the chip-select hold count, and the address is held for the address hold count. One forced idle cycle with every strobe high then separates this access from the next.

When page mode is on for a bank, a read fetches four consecutive words. The second, third and fourth words each use the shorter page access count. A small write port loads the configuration word of each bank. The sequencer takes a copy of the bank's settings when it accepts a request, so a configuration write that arrives during an access only affects later accesses.

Top module: `static_mem_ctrl`

## Requirements
- R1: Request address bits [25:24] select the bank, and only `mem_cs_n[bank]` goes low during the access. At most one chip-select line is low at any time, and it does not switch to another bank while low.
- R2: The configuration word for a bank is written with `cfg_we`/`cfg_bank`/`cfg_wdata`. Its layout is: [3:0] address setup, [7:4] chip-select setup, [12:8] access, [16:13] chip-select hold, [20:17] address hold, [24:21] page access, [25] 16-bit width when 1, [26] page read enable. After reset every field of every bank is 0, which means 8-bit width, page mode off and all counts zero.
- R3: The access runs in a fixed phase order, and each phase takes its programmed count of cycles:
  - address setup: cycles with all chip-selects high after the request is accepted;
  - chip-select setup: chip-select low with no strobe;
  - access: strobe low, lasting the access count + 1;
  - chip-select hold: chip-select low after the strobe rises;
  - address hold.
  A count of 0 skips its phase.
- R4: The access count is 5 bits wide, so a value of 31 keeps the strobe low for 32 cycles.
- R5: In 8-bit mode, `mem_addr` equals offset bits [23:0], read data returns with bits [15:8] zero, and `mem_dq_o[15:8]` is driven as zero. In 16-bit mode, `mem_addr` equals offset >> 1.
- R6: A read to a page-mode bank returns 4 words from `mem_addr` base, base+1, base+2 and base+3. Output-enable stays low across all four words. The first word lasts access+1 cycles, and each later word lasts the page count, or 1 cycle when the page count is 0. Writes to such a bank transfer a single word.
- R7: Read data is sampled in the last cycle of each word's access time. Each sample produces a `rsp_valid` pulse of one cycle in the cycle after it, with the data on `rsp_rdata`. Writes produce no response.
- R8: During a write, `mem_we_n` is low for the access time and `mem_oe_n` stays high. `mem_dq_oe` is high for exactly the cycles when chip-select is low, and `mem_dq_o` carries the write data.
- R9: A configuration write to a bank while that bank is being accessed leaves the ongoing access unchanged and applies from the next access on.
- R10: `req_ready` is high only when the bus is idle. At least one cycle with all chip-selects, `mem_oe_n` and `mem_we_n` high passes between the end of one access's address hold and the next acceptance, and no strobe is low while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_addr | input | 26 | Bank in [25:24], byte offset in [23:0] |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse per word |
| rsp_rdata | output | 16 | Read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Bank whose configuration is written |
| cfg_wdata | input | 27 | Configuration word (layout in R2) |
| mem_addr | output | 24 | External address |
| mem_cs_n | output | 4 | Active-low chip-selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 16 | Data driven to the bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data from the bus |

## Verification
The bench builds the block with its default parameters: four banks, a 26-bit request address, a 16-bit data bus and four-word pages. Directed accesses can therefore reach every chip-select line, both byte-lane widths and the full 5-bit access count up to its 32-cycle maximum. With four-word pages the bench also sees the hand-off from the first word's access time to the page time and the stop after the fourth word. A behavioural memory in the bench returns a known function of `mem_addr`, so returned data also confirms the address of each page word.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef struct packed {
    logic       page;
    logic       wide;
    logic [3:0] tpa;
    logic [3:0] tah;
    logic [3:0] tch;
    logic [4:0] tacc;
    logic [3:0] tcs;
    logic [3:0] tas;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);

  typedef enum logic [2:0] {
    PH_IDLE, PH_ASU, PH_CSU, PH_ACC, PH_CSH, PH_AHD, PH_GAP
  } phase_t;

  // Cycles spent in a phase; a zero-length phase is never entered.
  function automatic logic [5:0] phase_len(phase_t ph, bank_cfg_t c, logic [7:0] beat);
    logic [5:0] n;
    case (ph)
      PH_ASU:  n = 6'(c.tas);
      PH_CSU:  n = 6'(c.tcs);
      PH_ACC:  n = (beat == 8'd0) ? 6'(c.tacc) + 6'd1
                                  : ((c.tpa == 4'd0) ? 6'd1 : 6'(c.tpa));
      PH_CSH:  n = 6'(c.tch);
      PH_AHD:  n = 6'(c.tah);
      default: n = 6'd1;
    endcase
    return n;
  endfunction

  // Phase following ph, skipping those with a zero count.
  function automatic phase_t next_phase(phase_t ph, bank_cfg_t c);
    phase_t n;
    case (ph)
      PH_IDLE: n = (c.tas != 0) ? PH_ASU : ((c.tcs != 0) ? PH_CSU : PH_ACC);
      PH_ASU:  n = (c.tcs != 0) ? PH_CSU : PH_ACC;
      PH_CSU:  n = PH_ACC;
      PH_ACC:  n = (c.tch != 0) ? PH_CSH : ((c.tah != 0) ? PH_AHD : PH_GAP);
      PH_CSH:  n = (c.tah != 0) ? PH_AHD : PH_GAP;
      PH_AHD:  n = PH_GAP;
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction

  // External word address from the in-bank byte offset.
  function automatic logic [23:0] ext_addr(logic [23:0] off, logic wide, logic [7:0] beat);
    return (wide ? (off >> 1) : off) + 24'(beat);
  endfunction

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [BANK_W-1:0] rd_bank,
  output bank_cfg_t         rd_cfg
);

  bank_cfg_t cfg_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[b] <= '0;
      else if (wr_en && wr_bank == BANK_W'(b))
        cfg_q[b] <= bank_cfg_t'(wr_data);
    end
  end

  assign rd_cfg = cfg_q[rd_bank];

endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int PAGE_BEATS = 4,
  parameter int BEAT_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_wr,
  input  bank_cfg_t         cfg_in,
  output phase_t            ph_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              wide_o,
  output logic              wr_o,
  output logic              acc_end_o,
  output logic              ready_o
);

  phase_t            ph;
  logic [5:0]        cnt;
  logic [BEAT_W-1:0] beat;
  bank_cfg_t         cfg_q;
  logic              wr_q;
  logic              last_beat;
  phase_t            nph, nph_idle;

  assign last_beat = wr_q || !cfg_q.page || (beat == BEAT_W'(PAGE_BEATS - 1));
  assign nph       = next_phase(ph, cfg_q);
  assign nph_idle  = next_phase(PH_IDLE, cfg_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      beat  <= '0;
      cfg_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          cfg_q <= cfg_in;
          wr_q  <= start_wr;
          beat  <= '0;
          ph    <= nph_idle;
          cnt   <= phase_len(nph_idle, cfg_in, 8'd0) - 6'd1;
        end
        PH_GAP: ph <= PH_IDLE;
        default: begin
          if (cnt != 6'd0) begin
            cnt <= cnt - 6'd1;
          end else if (ph == PH_ACC && !last_beat) begin
            beat <= beat + 1'b1;
            cnt  <= phase_len(PH_ACC, cfg_q, 8'(beat) + 8'd1) - 6'd1;
          end else begin
            ph  <= nph;
            cnt <= phase_len(nph, cfg_q, 8'd0) - 6'd1;
          end
        end
      endcase
    end
  end

  assign ph_o      = ph;
  assign beat_o    = beat;
  assign wide_o    = cfg_q.wide;
  assign wr_o      = wr_q;
  assign acc_end_o = (ph == PH_ACC) && (cnt == 6'd0);
  assign ready_o   = (ph == PH_IDLE);

endmodule

// File: rtl/smc_dpath.sv
module smc_dpath
  import smc_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int OFF_W  = 24,
  parameter int DQ_W   = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] start_bank,
  input  logic [OFF_W-1:0]  start_off,
  input  logic [DQ_W-1:0]   start_wdata,
  input  phase_t            ph,
  input  logic [BEAT_W-1:0] beat,
  input  logic              wide,
  input  logic              wr,
  input  logic              sample,
  input  logic [DQ_W-1:0]   mem_dq_i,
  output logic [OFF_W-1:0]  mem_addr,
  output logic [NBANK-1:0]  mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DQ_W-1:0]   mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_rdata
);

  localparam int BYTE_W = DQ_W / 2;

  logic [BANK_W-1:0] bank_q;
  logic [OFF_W-1:0]  off_q;
  logic [DQ_W-1:0]   wdata_q;
  logic              addr_on, cs_on, acc_on;
  logic [DQ_W-1:0]   lane_in, lane_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      off_q   <= '0;
      wdata_q <= '0;
    end else if (start) begin
      bank_q  <= start_bank;
      off_q   <= start_off;
      wdata_q <= start_wdata;
    end
  end

  assign addr_on = (ph != PH_IDLE) && (ph != PH_GAP);
  assign cs_on   = (ph == PH_CSU) || (ph == PH_ACC) || (ph == PH_CSH);
  assign acc_on  = (ph == PH_ACC);

  assign mem_addr = addr_on ? OFF_W'(ext_addr(24'(off_q), wide, 8'(beat))) : '0;

  for (genvar b = 0; b < NBANK; b++) begin : g_cs
    assign mem_cs_n[b] = !(cs_on && bank_q == BANK_W'(b));
  end

  assign mem_oe_n  = !(acc_on && !wr);
  assign mem_we_n  = !(acc_on && wr);
  assign mem_dq_oe = cs_on && wr;

  assign lane_out = wide ? wdata_q : {{(DQ_W-BYTE_W){1'b0}}, wdata_q[BYTE_W-1:0]};
  assign mem_dq_o = mem_dq_oe ? lane_out : '0;
  assign lane_in  = wide ? mem_dq_i : {{(DQ_W-BYTE_W){1'b0}}, mem_dq_i[BYTE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= sample;
      if (sample) rsp_rdata <= lane_in;
    end
  end

endmodule

// File: rtl/static_mem_ctrl.sv
module static_mem_ctrl
  import smc_pkg::*;
#(
  parameter int NBANK      = 4,
  parameter int ADDR_W     = 26,
  parameter int DQ_W       = 16,
  parameter int PAGE_BEATS = 4,
  localparam int BANK_W    = $clog2(NBANK),
  localparam int OFF_W     = ADDR_W - BANK_W,
  localparam int BEAT_W    = (PAGE_BEATS > 1) ? $clog2(PAGE_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_rdata,
  input  logic              cfg_we,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [OFF_W-1:0]  mem_addr,
  output logic [NBANK-1:0]  mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DQ_W-1:0]   mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DQ_W-1:0]   mem_dq_i
);

  logic [BANK_W-1:0] req_bank;
  logic              accept_evt;
  logic              acc_end_evt;
  logic              sample_evt;
  bank_cfg_t         req_cfg;
  phase_t            ph;
  logic [BEAT_W-1:0] beat;
  logic              wide_act, wr_act;

  assign req_bank    = req_addr[ADDR_W-1 -: BANK_W];
  assign accept_evt  = req_valid && req_ready;
  assign sample_evt  = acc_end_evt && !wr_act;

  smc_cfg_regs #(.NBANK(NBANK), .BANK_W(BANK_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_bank(cfg_bank), .wr_data(cfg_wdata),
    .rd_bank(req_bank), .rd_cfg(req_cfg)
  );

  smc_seq #(.PAGE_BEATS(PAGE_BEATS), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(accept_evt), .start_wr(req_write), .cfg_in(req_cfg),
    .ph_o(ph), .beat_o(beat), .wide_o(wide_act), .wr_o(wr_act),
    .acc_end_o(acc_end_evt), .ready_o(req_ready)
  );

  smc_dpath #(.NBANK(NBANK), .BANK_W(BANK_W), .OFF_W(OFF_W), .DQ_W(DQ_W),
              .BEAT_W(BEAT_W)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .start(accept_evt), .start_bank(req_bank),
    .start_off(req_addr[OFF_W-1:0]), .start_wdata(req_wdata),
    .ph(ph), .beat(beat), .wide(wide_act), .wr(wr_act), .sample(sample_evt),
    .mem_dq_i(mem_dq_i),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/static_mem_ctrl_checker.sv
module static_mem_ctrl_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic [NBANK-1:0] mem_cs_n,
  input logic             mem_oe_n,
  input logic             mem_we_n,
  input logic             mem_dq_oe,
  input logic             rsp_valid,
  input logic             sample_evt
);

  a_r1_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  a_r1_cs_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '1 && $past(mem_cs_n) != '1) |-> $stable(mem_cs_n));

  a_r8_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r10_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1));

  a_r10_gap_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(mem_cs_n == '1 && mem_oe_n && mem_we_n));

  a_r8_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && mem_cs_n != '1));

  a_r7_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> rsp_valid);

  a_r7_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(sample_evt && !mem_oe_n));

endmodule

bind static_mem_ctrl static_mem_ctrl_checker #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_cs_n(mem_cs_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe),
  .rsp_valid(rsp_valid), .sample_evt(sample_evt)
);

// File: tb/static_mem_ctrl_bench.sv
module static_mem_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [25:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_bank = '0;
  logic [26:0] cfg_wdata = '0;
  logic [23:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] mdl(input logic [23:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] ^ a[7:0] ^ 8'h5A};
  endfunction

  assign mem_dq_i = !mem_oe_n ? mdl(mem_addr) : 16'hFFFF;

  static_mem_ctrl u_static_mem_ctrl (.*);

  // R2 layout: page[26] wide[25] tpa[24:21] tah[20:17] tch[16:13] tacc[12:8] tcs[7:4] tas[3:0]
  function automatic logic [26:0] cfgw(input bit pg, input bit wd, input int tpa,
      input int tah, input int tch, input int tacc, input int tcs, input int tas);
    return {pg, wd, 4'(tpa), 4'(tah), 4'(tch), 5'(tacc), 4'(tcs), 4'(tas)};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  int m_pre, m_csu, m_acc, m_csh, m_post, m_oe, m_we, m_dqoe, m_bad, m_rsp_n;
  logic [3:0]  m_cs;
  logic [23:0] m_addr;
  logic [15:0] m_dq;
  logic [15:0] m_rsp [8];

  task automatic cfg_write(input logic [1:0] b, input logic [26:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = b; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_access(input logic [25:0] a, input bit w, input logic [15:0] d);
    int st;
    bit cs, stb;
    m_pre = 0; m_csu = 0; m_acc = 0; m_csh = 0; m_post = 0; m_oe = 0; m_we = 0;
    m_dqoe = 0; m_bad = 0; m_rsp_n = 0; m_cs = 4'hF; m_addr = '0; m_dq = '0;
    st = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) begin
      cs  = (mem_cs_n != 4'hF);
      stb = !mem_oe_n || !mem_we_n;
      if (!mem_oe_n) m_oe++;
      if (!mem_we_n) m_we++;
      if (mem_dq_oe) m_dqoe++;
      if (stb && !cs) m_bad++;
      if (rsp_valid && m_rsp_n < 8) begin m_rsp[m_rsp_n] = rsp_rdata; m_rsp_n++; end
      if (!cs) begin
        if (st == 0) m_pre++; else begin st = 4; m_post++; end
      end else if (stb) begin
        if (st < 2) begin m_cs = mem_cs_n; m_addr = mem_addr; m_dq = mem_dq_o; end
        st = 2; m_acc++;
      end else if (st >= 2) begin
        st = 3; m_csh++;
      end else begin
        st = 1; m_csu++;
      end
      @(negedge clk);
    end
    if (rsp_valid) begin
      checks++; failures++;
      $display("FAIL R7 late response actual=1 expected=0");
    end
  endtask

  task automatic exp_phases(input string tag, input int pre, input int csu,
      input int acc, input int csh, input int post);
    chk({tag, " R3 addr setup"}, m_pre, pre);
    chk({tag, " R3 cs setup"}, m_csu, csu);
    chk({tag, " R3 access"}, m_acc, acc);
    chk({tag, " R3 cs hold"}, m_csh, csh);
    chk({tag, " R10 addr hold + idle gap"}, m_post, post);
    chk({tag, " R10 strobe outside cs"}, m_bad, 0);
  endtask

  task automatic t_reset();
    chk("R10 ready after reset", req_ready, 1);
    chk("R1 cs idle after reset", mem_cs_n, 4'hF);
    chk("R8 strobes idle after reset", {mem_oe_n, mem_we_n}, 2'b11);
    chk("R8 no drive after reset", mem_dq_oe, 0);
    chk("R7 no response after reset", rsp_valid, 0);
  endtask

  task automatic t_default_read();
    do_access(26'h000_0012, 1'b0, 16'h0);
    exp_phases("R2 default", 0, 0, 1, 0, 1);
    chk("R1 bank0 line", m_cs, 4'b1110);
    chk("R5 byte addr", m_addr, 24'h12);
    chk("R7 rsp count", m_rsp_n, 1);
    chk("R5 byte read data", m_rsp[0], {8'h00, mdl(24'h12) & 16'h00FF});
  endtask

  task automatic t_timed_wide_read();
    cfg_write(2'd1, cfgw(0, 1, 0, 2, 1, 4, 3, 2));
    do_access(26'h100_0100, 1'b0, 16'h0);
    exp_phases("bank1", 2, 3, 5, 1, 3);
    chk("R1 bank1 line", m_cs, 4'b1101);
    chk("R5 wide addr", m_addr, 24'h80);
    chk("R7 wide read data", m_rsp[0], mdl(24'h80));
  endtask

  task automatic t_writes();
    cfg_write(2'd2, cfgw(0, 1, 0, 0, 2, 2, 0, 1));
    do_access(26'h200_0040, 1'b1, 16'hBEEF);
    exp_phases("bank2 write", 1, 0, 3, 2, 1);
    chk("R8 we low cycles", m_we, 3);
    chk("R8 oe stays high", m_oe, 0);
    chk("R8 drive cycles", m_dqoe, 5);
    chk("R8 write data", m_dq, 16'hBEEF);
    chk("R1 bank2 line", m_cs, 4'b1011);
    chk("R7 no write rsp", m_rsp_n, 0);
    do_access(26'h000_0033, 1'b1, 16'hBEEF);
    chk("R5 byte write lane", m_dq, 16'h00EF);
    chk("R5 byte write addr", m_addr, 24'h33);
  endtask

  task automatic t_page();
    cfg_write(2'd3, cfgw(1, 1, 2, 0, 0, 1, 1, 0));
    do_access(26'h300_0010, 1'b0, 16'h0);
    exp_phases("R6 page", 0, 1, 8, 0, 1);
    chk("R6 oe held across words", m_oe, 8);
    chk("R7 one rsp per word", m_rsp_n, 4);
    for (int i = 0; i < 4; i++)
      chk($sformatf("R6 page word %0d", i), m_rsp[i], mdl(24'(8 + i)));
    chk("R1 bank3 line", m_cs, 4'b0111);
    do_access(26'h300_0010, 1'b1, 16'h1234);
    chk("R6 page write single", m_we, 2);
    chk("R6 page write no rsp", m_rsp_n, 0);
    cfg_write(2'd3, cfgw(1, 1, 0, 0, 0, 1, 1, 0));
    do_access(26'h300_0010, 1'b0, 16'h0);
    chk("R6 zero page count", m_acc, 5);
    chk("R6 zero page rsp", m_rsp_n, 4);
  endtask

  task automatic t_max_access();
    cfg_write(2'd0, cfgw(0, 0, 0, 0, 0, 31, 0, 0));
    do_access(26'h000_0001, 1'b0, 16'h0);
    chk("R4 access 31", m_acc, 32);
    chk("R4 data at max", m_rsp[0], {8'h00, mdl(24'h1) & 16'h00FF});
  endtask

  task automatic t_cfg_mid_access();
    fork
      do_access(26'h100_0100, 1'b0, 16'h0);
      begin
        repeat (4) @(negedge clk);
        cfg_we = 1'b1; cfg_bank = 2'd1; cfg_wdata = cfgw(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join
    exp_phases("R9 old cfg kept", 2, 3, 5, 1, 3);
    chk("R9 old width kept", m_rsp[0], mdl(24'h80));
    do_access(26'h100_0100, 1'b0, 16'h0);
    exp_phases("R9 new cfg", 0, 0, 1, 0, 1);
    chk("R9 new width addr", m_addr, 24'h100);
  endtask

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_default_read();
    t_timed_wide_read();
    t_writes();
    t_page();
    t_max_access();
    t_cfg_mid_access();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule